// File: doc/BRIEF.md
# On-deck loop counter controller

This block sits at the on-deck stage of a dock's recirculating instruction ring. It holds the two loop counters: a single-instruction inner counter, which may also hold an unbounded (infinity) value, and a multi-instruction outer counter. For the instruction now on deck it decides whether the instruction executes, how many times it repeats, whether a copy of it goes back into the instruction FIFO, and when the on-deck slot may be vacated. It also takes a waiting torpedo when the on-deck instruction allows it.

The surrounding dock decodes the instruction and evaluates the flag predicate, then presents the opcode, the one-shot and interruptible bits, the predicate result and the counter-load fields of a `set` instruction. The controller answers each cycle with combinational execute, recycle, retire and torpedo-acknowledge strobes. The counters are updated at the clock edge. Whenever the outer counter is written with zero, a registered hatch-unseal pulse follows one cycle later.

Top module: `dock_loop_ctrl`

## Requirements
- R1: A move (op 00) whose predicate is true and whose inner count is finite value k raises exec_o on k+1 consecutive on-deck cycles. The count drops by one after each execution except the last. It is 0 afterwards, and retire_o rises with the last execution.
- R2: When the inner counter holds infinity, a move with a true predicate raises exec_o on every cycle and never retires on its own. The infinity flag stays set.
- R3: An instruction whose predicate is false never raises exec_o and leaves both counters unchanged. Shift (op 01), and set instructions that do not target a counter, execute without changing the inner counter.
- R4: exec_o is never raised while the outer counter is 0. The one exception is a set with DST=00 (outer counter) and the one-shot bit at 1.
- R5: For an instruction with the one-shot bit at 0, requeue_o pulses for exactly one cycle, in a cycle where hatch_sealed_i is 1 and the outer counter is nonzero, whatever the predicate. One-shot instructions never raise requeue_o.
- R6: An instruction with the one-shot bit at 0 may execute while the hatch is unsealed. retire_o stays low until both its execution and its recycle have happened.
- R7: A set with DST=00 loads the outer counter from the payload (SRC=00), the data input (SRC=01), or its own value minus one, saturating at 0 (SRC=10).
- R8: A set with DST=01 loads the inner counter from the payload (SRC=00) or the data input (SRC=01), which clears infinity, or sets infinity with count 0 (SRC=10). DST=10 and DST=11 leave both counters unchanged.
- R9: With torpedo_i high, the torpedo is taken only if the predicate is true, the interruptible bit is 1, and either the one-shot bit is 1 or the outer counter is nonzero. Taking it raises torp_ack_o and retire_o without exec_o or requeue_o, and leaves both counters at 0 with infinity cleared. Otherwise torp_ack_o stays low.
- R10: unseal_o is high for one cycle, in the cycle after any write of zero to the outer counter (set load or torpedo).
- R11: After reset, both counters are 0, infinity is clear, and unseal_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| od_valid_i | input | 1 | An instruction is on deck |
| op_i | input | 2 | Opcode: 00 move, 01 shift, 10 set, 11 no counter effect |
| os_i | input | 1 | One-shot bit |
| intr_i | input | 1 | Interruptible bit |
| pred_i | input | 1 | Predicate result |
| set_src_i | input | 2 | Set source select |
| set_dst_i | input | 2 | Set destination select |
| payload_i | input | CNT_W | Set payload bits |
| data_i | input | CNT_W | Data latch bits |
| hatch_sealed_i | input | 1 | Hatch is sealed |
| torpedo_i | input | 1 | A torpedo is waiting |
| exec_o | output | 1 | Instruction executes this cycle |
| requeue_o | output | 1 | Copy of instruction enters the FIFO |
| retire_o | output | 1 | On-deck slot vacates |
| torp_ack_o | output | 1 | Torpedo taken |
| unseal_o | output | 1 | Hatch-unseal pulse |
| ilc_o | output | CNT_W | Inner counter value |
| ilc_inf_o | output | 1 | Inner counter holds infinity |
| olc_o | output | CNT_W | Outer counter value |

## Verification
The bench targets these corner cases:
- **Outer decrement at zero.** It must saturate. A wrapping design would leave the counter at all ones.
- **One-shot outer load while the counter is zero.** It must still execute. A design that applies the outer gate to everything would deadlock the loop.
- **Inner repeat count.** A design off by one in ILC+1 shows up as one exec_o cycle too many or too few.
- **Recycle while the predicate is false.** It must still happen. A design that gates recycle on the predicate would drop the instruction from the loop.
- **Torpedo against a non-one-shot instruction while the outer counter is zero.** It must not be taken.
- **Torpedo during an infinite inner loop.** It must end the loop and clear infinity.

// File: rtl/dock_loop_pkg.sv
package dock_loop_pkg;
  typedef enum logic [1:0] {
    OP_MOVE  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_SET   = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    DST_OUTER = 2'b00,
    DST_INNER = 2'b01,
    DST_MISC  = 2'b10,
    DST_FLAG  = 2'b11
  } dst_e;

  typedef enum logic [1:0] {
    SRC_PAY  = 2'b00,
    SRC_DATA = 2'b01,
    SRC_ALT  = 2'b10,
    SRC_NONE = 2'b11
  } src_e;
endpackage

// File: rtl/odl_gate.sv
module odl_gate
  import dock_loop_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic [1:0] dst_i,
  input  logic       os_i,
  input  logic       intr_i,
  input  logic       pred_i,
  input  logic       olc_pos_i,
  output logic       exec_en_o,
  output logic       torp_en_o,
  output logic       inner_o,
  output logic       recycle_o
);
  logic exempt;

  // one-shot outer-counter load bypasses the outer gate
  assign exempt    = (op_i == OP_SET) && (dst_i == DST_OUTER) && os_i;
  assign exec_en_o = pred_i && (exempt || olc_pos_i);
  assign torp_en_o = pred_i && intr_i && (os_i || olc_pos_i);
  assign inner_o   = (op_i == OP_MOVE);
  assign recycle_o = !os_i && olc_pos_i;
endmodule

// File: rtl/odl_ilc.sv
module odl_ilc #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             load_i,
  input  logic             load_inf_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inf_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             inf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      inf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      inf_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_inf_i ? '0 : load_val_i;
      inf_q <= load_inf_i;
    end else if (step_i && !inf_q && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign inf_o  = inf_q;
  assign last_o = !inf_q && (cnt_q == '0);

  p_inf_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && inf_q && !clr_i && !load_i |=> inf_q);
  p_step_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !inf_q && (cnt_q != '0) && !clr_i && !load_i
      |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/odl_olc.sv
module odl_olc
  import dock_loop_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] payload_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pos_o,
  output logic             unseal_o
);
  logic [CNT_W-1:0] cnt_q, load_val, cnt_d;
  logic             wr, unseal_q;

  always_comb begin
    unique case (sel_i)
      SRC_PAY:  load_val = payload_i;
      SRC_DATA: load_val = data_i;
      SRC_ALT:  load_val = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
      default:  load_val = cnt_q;
    endcase
  end

  assign wr    = clr_i || load_i;
  assign cnt_d = clr_i ? '0 : load_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      unseal_q <= 1'b0;
    end else begin
      if (wr) cnt_q <= cnt_d;
      unseal_q <= wr && (cnt_d == '0);
    end
  end

  assign cnt_o    = cnt_q;
  assign pos_o    = (cnt_q != '0);
  assign unseal_o = unseal_q;

  p_unseal_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unseal_q |-> cnt_q == '0);
  p_dec_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i && sel_i == SRC_ALT && cnt_q == '0 |=> cnt_q == '0);
endmodule

// File: rtl/dock_loop_ctrl.sv
module dock_loop_ctrl
  import dock_loop_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             od_valid_i,
  input  logic [1:0]       op_i,
  input  logic             os_i,
  input  logic             intr_i,
  input  logic             pred_i,
  input  logic [1:0]       set_src_i,
  input  logic [1:0]       set_dst_i,
  input  logic [CNT_W-1:0] payload_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             hatch_sealed_i,
  input  logic             torpedo_i,
  output logic             exec_o,
  output logic             requeue_o,
  output logic             retire_o,
  output logic             torp_ack_o,
  output logic             unseal_o,
  output logic [CNT_W-1:0] ilc_o,
  output logic             ilc_inf_o,
  output logic [CNT_W-1:0] olc_o
);
  logic olc_pos, exec_en, torp_en, inner, recycle, ilc_last;
  logic exec_done_q, req_done_q;
  logic torp_fire, exec_fire, exec_finish, req_fire, exec_part, req_part, retire;
  logic set_fire, olc_load, ilc_load;

  odl_gate u_gate (
    .op_i      (op_i),
    .dst_i     (set_dst_i),
    .os_i      (os_i),
    .intr_i    (intr_i),
    .pred_i    (pred_i),
    .olc_pos_i (olc_pos),
    .exec_en_o (exec_en),
    .torp_en_o (torp_en),
    .inner_o   (inner),
    .recycle_o (recycle)
  );

  assign torp_fire   = od_valid_i && torpedo_i && torp_en;
  assign exec_fire   = od_valid_i && !torp_fire && exec_en && !exec_done_q;
  assign exec_finish = exec_fire && (!inner || ilc_last);
  assign req_fire    = od_valid_i && !torp_fire && recycle && hatch_sealed_i && !req_done_q;
  assign exec_part   = exec_done_q || exec_finish || !exec_en;
  assign req_part    = req_done_q || req_fire || !recycle;
  assign retire      = od_valid_i && (torp_fire || (exec_part && req_part));

  assign set_fire = exec_fire && (op_i == OP_SET) && (set_src_i != SRC_NONE);
  assign olc_load = set_fire && (set_dst_i == DST_OUTER);
  assign ilc_load = set_fire && (set_dst_i == DST_INNER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_done_q <= 1'b0;
      req_done_q  <= 1'b0;
    end else if (retire) begin
      exec_done_q <= 1'b0;
      req_done_q  <= 1'b0;
    end else begin
      exec_done_q <= exec_done_q || exec_finish;
      req_done_q  <= req_done_q || req_fire;
    end
  end

  odl_ilc #(.CNT_W(CNT_W)) u_ilc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (torp_fire),
    .step_i     (exec_fire && inner),
    .load_i     (ilc_load),
    .load_inf_i (set_src_i == SRC_ALT),
    .load_val_i ((set_src_i == SRC_DATA) ? data_i : payload_i),
    .cnt_o      (ilc_o),
    .inf_o      (ilc_inf_o),
    .last_o     (ilc_last)
  );

  odl_olc #(.CNT_W(CNT_W)) u_olc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (torp_fire),
    .load_i    (olc_load),
    .sel_i     (set_src_i),
    .payload_i (payload_i),
    .data_i    (data_i),
    .cnt_o     (olc_o),
    .pos_o     (olc_pos),
    .unseal_o  (unseal_o)
  );

  assign exec_o     = exec_fire;
  assign requeue_o  = req_fire;
  assign retire_o   = retire;
  assign torp_ack_o = torp_fire;

  p_outer_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && olc_o == '0 |-> op_i == OP_SET && set_dst_i == DST_OUTER && os_i);
  p_requeue_sealed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    requeue_o |-> hatch_sealed_i && !os_i && olc_o != '0);
  p_torp_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    torp_ack_o |=> olc_o == '0 && ilc_o == '0 && !ilc_inf_o);
  p_torp_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    torp_ack_o |-> !exec_o && !requeue_o && retire_o);
  p_no_pred_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_i |-> !exec_o && !torp_ack_o);
  p_single_requeue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    requeue_o && !retire_o |=> !requeue_o);
endmodule

// File: tb/dock_loop_ctrl_tb_top.sv
module dock_loop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic od_valid = 1'b0, os = 1'b1, intr = 1'b0, pred = 1'b0, sealed = 1'b0, torp = 1'b0;
  logic [1:0] op = 2'b01, src = 2'b00, dst = 2'b00;
  logic [CW-1:0] pay = '0, dat = '0;
  logic exec, requeue, retire, tack, unseal, inf;
  logic [CW-1:0] ilc, olc;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dock_loop_ctrl #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .od_valid_i(od_valid), .op_i(op), .os_i(os),
    .intr_i(intr), .pred_i(pred), .set_src_i(src), .set_dst_i(dst),
    .payload_i(pay), .data_i(dat), .hatch_sealed_i(sealed), .torpedo_i(torp),
    .exec_o(exec), .requeue_o(requeue), .retire_o(retire), .torp_ack_o(tack),
    .unseal_o(unseal), .ilc_o(ilc), .ilc_inf_o(inf), .olc_o(olc)
  );

  typedef struct packed {
    logic [1:0] op; logic [1:0] src; logic [1:0] dst; logic pred;
    logic [5:0] pay; logic [5:0] dat;
    logic e_exec; logic [5:0] e_olc; logic [5:0] e_ilc; logic e_inf; logic e_uns;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd2,2'd0,2'd0,1'b1,6'd5, 6'd0,1'b1,6'd5, 6'd0,1'b0,1'b0},
    '{2'd2,2'd0,2'd1,1'b1,6'd3, 6'd0,1'b1,6'd5, 6'd3,1'b0,1'b0},
    '{2'd2,2'd1,2'd0,1'b1,6'd0, 6'd9,1'b1,6'd9, 6'd3,1'b0,1'b0},
    '{2'd2,2'd2,2'd0,1'b1,6'd0, 6'd0,1'b1,6'd8, 6'd3,1'b0,1'b0},
    '{2'd2,2'd2,2'd1,1'b1,6'd0, 6'd0,1'b1,6'd8, 6'd0,1'b1,1'b0},
    '{2'd2,2'd1,2'd1,1'b1,6'd0, 6'd7,1'b1,6'd8, 6'd7,1'b0,1'b0},
    '{2'd2,2'd0,2'd2,1'b1,6'd12,6'd0,1'b1,6'd8, 6'd7,1'b0,1'b0},
    '{2'd2,2'd0,2'd3,1'b1,6'd0, 6'd0,1'b1,6'd8, 6'd7,1'b0,1'b0},
    '{2'd1,2'd0,2'd0,1'b1,6'd0, 6'd0,1'b1,6'd8, 6'd7,1'b0,1'b0},
    '{2'd2,2'd0,2'd1,1'b0,6'd2, 6'd0,1'b0,6'd8, 6'd7,1'b0,1'b0},
    '{2'd0,2'd0,2'd0,1'b0,6'd0, 6'd0,1'b0,6'd8, 6'd7,1'b0,1'b0},
    '{2'd2,2'd0,2'd0,1'b1,6'd0, 6'd0,1'b1,6'd0, 6'd7,1'b0,1'b1},
    '{2'd2,2'd0,2'd1,1'b1,6'd4, 6'd0,1'b0,6'd0, 6'd7,1'b0,1'b0},
    '{2'd2,2'd0,2'd0,1'b1,6'd1, 6'd0,1'b1,6'd1, 6'd7,1'b0,1'b0},
    '{2'd2,2'd2,2'd0,1'b1,6'd0, 6'd0,1'b1,6'd0, 6'd7,1'b0,1'b1},
    '{2'd2,2'd2,2'd0,1'b1,6'd0, 6'd0,1'b1,6'd0, 6'd7,1'b0,1'b1},
    '{2'd2,2'd0,2'd0,1'b1,6'd63,6'd0,1'b1,6'd63,6'd7,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] o, input logic s_os, input logic s_in, input logic p,
                       input logic [1:0] sr, input logic [1:0] ds, input logic [CW-1:0] py,
                       input logic [CW-1:0] dt, input logic hs, input logic tp);
    @(negedge clk);
    od_valid = 1'b1; op = o; os = s_os; intr = s_in; pred = p; src = sr; dst = ds;
    pay = py; dat = dt; sealed = hs; torp = tp;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // R11 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R11 olc", olc, 0); chk("R11 ilc", ilc, 0);
    chk("R11 inf", inf, 0); chk("R11 unseal", unseal, 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R11 idle exec", exec, 0);

    // table walk: one-shot instructions, counter loads and gating (R3 R4 R7 R8 R10)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, 1'b1, 1'b0, VECS[i].pred, VECS[i].src, VECS[i].dst,
            VECS[i].pay, VECS[i].dat, 1'b0, 1'b0);
      chk($sformatf("R4 R3 vec%0d exec", i), exec, VECS[i].e_exec);
      chk($sformatf("R5 vec%0d retire", i), retire, 1);
      tick();
      chk($sformatf("R7 vec%0d olc", i), olc, VECS[i].e_olc);
      chk($sformatf("R8 vec%0d ilc", i), ilc, VECS[i].e_ilc);
      chk($sformatf("R8 vec%0d inf", i), inf, VECS[i].e_inf);
      chk($sformatf("R10 vec%0d unseal", i), unseal, VECS[i].e_uns);
    end

    // R1: inner count 2 -> three executions
    drive(2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 6'd2, 6'd0, 1'b0, 1'b0); tick();
    for (int k = 0; k < 3; k++) begin
      drive(2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b0, 1'b0);
      chk("R1 move exec", exec, 1);
      chk("R1 move retire", retire, (k == 2) ? 1 : 0);
      tick();
      chk("R1 ilc after", ilc, (k == 0) ? 1 : 0);
    end

    // R2: infinite inner loop, then torpedo (R9 R10)
    drive(2'd2, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 6'd0, 6'd0, 1'b0, 1'b0); tick();
    for (int k = 0; k < 4; k++) begin
      drive(2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b0, 1'b0);
      chk("R2 inf exec", exec, 1);
      chk("R2 inf retire", retire, 0);
      tick();
      chk("R2 inf held", inf, 1);
    end
    drive(2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b0, 1'b1);
    chk("R9 torp ack", tack, 1); chk("R9 torp no exec", exec, 0);
    chk("R9 torp retire", retire, 1);
    tick();
    chk("R9 olc cleared", olc, 0); chk("R9 ilc cleared", ilc, 0);
    chk("R9 inf cleared", inf, 0); chk("R10 unseal after torpedo", unseal, 1);

    // R9: non-one-shot at OLC=0 is not torpedoable
    drive(2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b1, 1'b1);
    chk("R9 blocked ack", tack, 0); chk("R4 blocked exec", exec, 0);
    chk("R5 no requeue at zero", requeue, 0); chk("R4 blocked retire", retire, 1);
    tick();
    chk("R10 unseal one cycle", unseal, 0);
    drive(2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b0, 1'b1);
    chk("R9 one-shot torpedo ack", tack, 1);
    tick();

    // R5 R6: recycle waits for the hatch
    drive(2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 6'd3, 6'd0, 1'b0, 1'b0); tick();
    drive(2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b0, 1'b0);
    chk("R6 exec before seal", exec, 1); chk("R6 hold", retire, 0);
    chk("R5 no requeue unsealed", requeue, 0);
    tick();
    drive(2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b0, 1'b0);
    chk("R6 no second exec", exec, 0); chk("R6 still held", retire, 0);
    tick();
    drive(2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b1, 1'b0);
    chk("R5 requeue on seal", requeue, 1); chk("R6 retire", retire, 1);
    chk("R6 exec once", exec, 0);
    tick();
    drive(2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b1, 1'b0);
    chk("R5 same-cycle exec", exec, 1); chk("R5 same-cycle requeue", requeue, 1);
    chk("R5 same-cycle retire", retire, 1);
    tick();
    drive(2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 1'b1, 1'b0);
    chk("R5 pred false requeue", requeue, 1); chk("R3 pred false exec", exec, 0);
    tick();
    drive(2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 6'd0, 6'd0, 1'b1, 1'b0);
    chk("R5 one-shot no requeue", requeue, 0);
    tick();
    chk("R7 olc kept", olc, 3);

    @(negedge clk); od_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule